// File: doc/BRIEF.md
# Shared-Bus Channel Enable Latches

This block keeps the per-channel enable state of a four-channel serial transceiver. One 8-bit enable bus is shared by two register banks. The receive bank is loaded under its own strobe and sets which receivers are powered. The output bank is loaded under a second, independent strobe and sets which serial line drivers are on. While a bank's strobe is high, the bank follows the bus. When the strobe drops, the bank keeps the value it last took.

Each channel owns two adjacent bus bits, 2c and 2c+1, one for each of its two serial driver outputs. The receive bank keeps one bit per channel, chosen by the `RX_BIT_SEL` parameter. From the two banks the block produces:
- receiver enables,
- the eight driver enables,
- a channel-logic power enable that is high while either driver of the channel is on,
- a link-fault flag that is forced high while the receiver is off,
- a status-valid flag that stays low for a settle interval after a receiver is switched on.

Both banks are clocked registers that load only when their strobe is high, so no real latches are built.

Top module: `chen_enable_ctrl`

## Requirements
- R1: While `rx_le_i` is high at a rising clock edge, `rx_en_o` takes the bus value on that edge (one clock of latency).
- R2: While `rx_le_i` is low, `rx_en_o` holds. The held value is the bus as sampled at the last edge on which `rx_le_i` was high.
- R3: With `RX_BIT_SEL`=0, receiver c is controlled by bus bit 2c only. Bus bit 2c+1 has no effect on `rx_en_o`.
- R4: While `out_le_i` is high at an edge, `drv_en_o[i]` takes bus bit i. While `out_le_i` is low, `drv_en_o` holds.
- R5: `logic_pwr_o[c]` is high exactly when `drv_en_o[2c]` or `drv_en_o[2c+1]` is high. It updates on the same edge as `drv_en_o`.
- R6: `link_fault_o[c]` is high when `rx_fault_raw_i[c]` is high or receiver c is disabled. It updates on the same edge as `rx_en_o`.
- R7: `status_valid_o[c]` is low while receiver c is disabled. After receiver c turns on at an edge, the flag rises SETTLE_CYCLES edges later. Disabling the receiver before then restarts the interval.
- R8: Synchronous reset clears all enables, `logic_pwr_o` and `status_valid_o`, and sets every `link_fault_o` bit.
- R9: The two strobes are independent. `rx_le_i` never changes `drv_en_o`, and `out_le_i` never changes `rx_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_bus_i | input | 8 | Shared enable bus, two bits per channel |
| rx_le_i | input | 1 | Receive bank load strobe |
| out_le_i | input | 1 | Output bank load strobe |
| rx_fault_raw_i | input | 4 | Link fault reported by each receiver |
| rx_en_o | output | 4 | Receiver enables |
| drv_en_o | output | 8 | Serial driver enables |
| logic_pwr_o | output | 4 | Channel logic power enables |
| link_fault_o | output | 4 | Link-fault flags, forced high when the receiver is off |
| status_valid_o | output | 4 | Receiver output valid after the settle interval |

## Verification
The assertions assume that the bus, both strobes and the raw fault inputs are synchronous to `clk`, and that each value stays fixed for whole clock periods. They also assume SETTLE_CYCLES is at least one. The stimulus changes every input one nanosecond after a rising edge and keeps it through the next edge. The bench shortens the settle interval to five cycles so that the rise of the valid flag can be checked on its exact edge.

// File: rtl/chen_pkg.sv
package chen_pkg;
  // Bus bit that belongs to lane `sel` of channel `ch`.
  function automatic int lane_bit(input int ch, input int sel);
    return 2 * ch + sel;
  endfunction
endpackage

// File: rtl/chen_latch_bank.sv
module chen_latch_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  always_comb q_next = le ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  assert_follow_R1: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(d)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(q));
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/chen_settle_timer.sv
module chen_settle_timer #(
  parameter int SETTLE_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_next,
  output logic valid
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;
  logic          en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      en_q  <= 1'b0;
      valid <= 1'b0;
    end else begin
      en_q <= en_next;
      if (!en_next) begin
        cnt   <= '0;
        valid <= 1'b0;
      end else if (!en_q) begin
        cnt   <= LOAD;
        valid <= 1'b0;
      end else if (cnt != '0) begin
        cnt   <= cnt - 1'b1;
        valid <= (cnt == CW'(1));
      end
    end
  end

  assert_valid_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !valid);
  assert_enable_starts_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> !valid);
endmodule

// File: rtl/chen_enable_ctrl.sv
module chen_enable_ctrl #(
  parameter int NUM_CH        = 4,
  parameter int RX_BIT_SEL    = 0,
  parameter int SETTLE_CYCLES = 1000000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_CH-1:0]   en_bus_i,
  input  logic                  rx_le_i,
  input  logic                  out_le_i,
  input  logic [NUM_CH-1:0]     rx_fault_raw_i,
  output logic [NUM_CH-1:0]     rx_en_o,
  output logic [2*NUM_CH-1:0]   drv_en_o,
  output logic [NUM_CH-1:0]     logic_pwr_o,
  output logic [NUM_CH-1:0]     link_fault_o,
  output logic [NUM_CH-1:0]     status_valid_o
);
  import chen_pkg::*;

  localparam int BUS_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] rx_sel;
  logic [NUM_CH-1:0] rx_next;
  logic [BUS_W-1:0]  drv_next;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign rx_sel[c] = en_bus_i[lane_bit(c, RX_BIT_SEL)];
  end

  chen_latch_bank #(.W(NUM_CH)) u_rx_bank (
    .clk(clk), .rst(rst), .le(rx_le_i), .d(rx_sel),
    .q(rx_en_o), .q_next(rx_next)
  );

  chen_latch_bank #(.W(BUS_W)) u_out_bank (
    .clk(clk), .rst(rst), .le(out_le_i), .d(en_bus_i),
    .q(drv_en_o), .q_next(drv_next)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        logic_pwr_o[c]  <= 1'b0;
        link_fault_o[c] <= 1'b1;
      end else begin
        logic_pwr_o[c]  <= drv_next[lane_bit(c, 0)] | drv_next[lane_bit(c, 1)];
        link_fault_o[c] <= rx_fault_raw_i[c] | ~rx_next[c];
      end
    end

    chen_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk(clk), .rst(rst), .en_next(rx_next[c]), .valid(status_valid_o[c])
    );

    assert_pwr_pair_R5: assert property (@(posedge clk) disable iff (rst)
      logic_pwr_o[c] == (drv_en_o[2*c] | drv_en_o[2*c+1]));
    assert_fault_forced_R6: assert property (@(posedge clk) disable iff (rst)
      !rx_en_o[c] |-> link_fault_o[c]);
    assert_valid_off_R7: assert property (@(posedge clk) disable iff (rst)
      !rx_en_o[c] |-> !status_valid_o[c]);
  end

  assert_rx_indep_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_le_i |=> $stable(rx_en_o));
  assert_out_indep_R9: assert property (@(posedge clk) disable iff (rst)
    !out_le_i |=> $stable(drv_en_o));
  assert_reset_fault_R8: assert property (@(posedge clk)
    rst |=> (link_fault_o == '1 && status_valid_o == '0));
endmodule

// File: tb/test_chen_enable_ctrl.sv
`timescale 1ns/1ps
module test_chen_enable_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus = '0;
  logic       rxle = 1'b0, oele = 1'b0;
  logic [3:0] raw = '0;
  logic [3:0] rx_en, pwr, flt, vld;
  logic [7:0] drv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chen_enable_ctrl #(.NUM_CH(4), .RX_BIT_SEL(0), .SETTLE_CYCLES(5)) i_chen_enable_ctrl (
    .clk(clk), .rst(rst), .en_bus_i(bus), .rx_le_i(rxle), .out_le_i(oele),
    .rx_fault_raw_i(raw), .rx_en_o(rx_en), .drv_en_o(drv), .logic_pwr_o(pwr),
    .link_fault_o(flt), .status_valid_o(vld)
  );

  // {rxle, oele, bus, raw, exp rx, exp drv, exp pwr, exp fault}
  localparam logic [33:0] VEC [10] = '{
    {1'b1, 1'b0, 8'h55, 4'h0, 4'hF, 8'h00, 4'h0, 4'h0},
    {1'b0, 1'b0, 8'h00, 4'h0, 4'hF, 8'h00, 4'h0, 4'h0},
    {1'b0, 1'b1, 8'hA0, 4'h0, 4'hF, 8'hA0, 4'hC, 4'h0},
    {1'b0, 1'b0, 8'hFF, 4'h0, 4'hF, 8'hA0, 4'hC, 4'h0},
    {1'b1, 1'b1, 8'h0C, 4'h0, 4'h2, 8'h0C, 4'h2, 4'hD},
    {1'b0, 1'b0, 8'h33, 4'h2, 4'h2, 8'h0C, 4'h2, 4'hF},
    {1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 8'h0C, 4'h2, 4'hD},
    {1'b1, 1'b0, 8'h02, 4'h0, 4'h0, 8'h0C, 4'h2, 4'hF},
    {1'b1, 1'b0, 8'h41, 4'h8, 4'h9, 8'h0C, 4'h2, 4'hE},
    {1'b0, 1'b1, 8'h03, 4'h0, 4'h9, 8'h03, 4'h1, 4'h6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R8 rx_en reset", {4'h0, rx_en}, 8'h00);
    check("R8 fault reset", {4'h0, flt}, 8'h0F);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R9: table walk
    for (int i = 0; i < 10; i++) begin
      {rxle, oele, bus, raw} = VEC[i][33:20];
      step();
      check("R1/R2/R3/R9 rx_en", {4'h0, rx_en}, {4'h0, VEC[i][19:16]});
      check("R4/R9 drv_en", drv, VEC[i][15:8]);
      check("R5 logic_pwr", {4'h0, pwr}, {4'h0, VEC[i][7:4]});
      check("R6 link_fault", {4'h0, flt}, {4'h0, VEC[i][3:0]});
    end

    // R8: reset in the middle of a run
    rst = 1'b1; rxle = 1'b0; oele = 1'b0; raw = '0; bus = '0;
    step();
    check("R8 rx_en", {4'h0, rx_en}, 8'h00);
    check("R8 drv_en", drv, 8'h00);
    check("R8 pwr", {4'h0, pwr}, 8'h00);
    check("R8 fault", {4'h0, flt}, 8'h0F);
    check("R8 valid", {4'h0, vld}, 8'h00);
    rst = 1'b0;

    // R7: settle interval of 5 edges
    rxle = 1'b1; bus = 8'h01;
    step();
    check("R7 enabled", {4'h0, rx_en}, 8'h01);
    check("R7 valid low at enable", {4'h0, vld}, 8'h00);
    rxle = 1'b0; bus = 8'hFF;
    step(); step(); step();
    step();
    check("R7 valid low at 4", {4'h0, vld}, 8'h00);
    step();
    check("R7 valid high at 5", {4'h0, vld}, 8'h01);

    // R7/R6: disable clears valid and forces fault
    rxle = 1'b1; bus = 8'h00;
    step();
    check("R7 valid off", {4'h0, vld}, 8'h00);
    check("R6 fault forced", {4'h0, flt}, 8'h0F);

    // R7: disable mid-count restarts the interval
    bus = 8'h01;
    step();
    rxle = 1'b0;
    step(); step();
    rxle = 1'b1; bus = 8'h00;
    step();
    check("R7 aborted", {4'h0, vld}, 8'h00);
    bus = 8'h01;
    step();
    rxle = 1'b0;
    step(); step(); step(); step();
    check("R7 restart low at 4", {4'h0, vld}, 8'h00);
    step();
    check("R7 restart high at 5", {4'h0, vld}, 8'h01);

    // R3: odd bits alone leave receivers off
    rxle = 1'b1; bus = 8'hAA;
    step();
    check("R3 odd bits", {4'h0, rx_en}, 8'h00);
    check("R7 valid after odd", {4'h0, vld}, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule